// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the timing strobes for a serial port that runs in three ways: asynchronous, clocked master and clocked slave. All of its outputs are enables of one system-clock cycle. A divisor counter sets the base rate. A post-divider turns base ticks into transmit strobes. In slave mode an edge detector on a synchronised external clock input takes the place of both.

The base counter counts down at the system clock. It reloads from the divisor input when it reaches zero, and it also reloads when the divisor's low byte is written. Each time it reaches zero it gives one base tick, so the base rate is fclk/(divisor+1). The receive enable is the base tick itself. The recovery logic downstream samples it 16, 8 or 2 times per bit. The transmit enable is the base tick divided by 16 (asynchronous), by 8 (asynchronous double speed) or by 2 (clocked master). In master mode the halved tick is also driven out as the shared serial clock.

Top module: `sclk_gen_top`

## Requirements
- R1: With no divisor write pending, `rx_tick` pulses once every divisor+1 cycles. After reset the first pulse comes in the first cycle.
- R2: A one-cycle `div_lo_wr` loads the counter with `div_value` on that edge. That edge gives no base tick, even if the counter was at zero. The next base tick follows div_value+1 cycles later.
- R3: Asynchronous mode (`sync_sel`=0, `speed2x`=0): `tx_tick` pulses together with every 16th base tick. The first such pulse falls on the 16th tick after reset.
- R4: Asynchronous double speed (`sync_sel`=0, `speed2x`=1): `tx_tick` pulses together with every 8th base tick.
- R5: Clocked master (`sync_sel`=1, `clk_dir`=1): `tx_tick` pulses together with every 2nd base tick. `speed2x` has no effect.
- R6: In clocked master mode `clk_out` toggles on each base tick and falls in the cycle when `tx_tick` pulses. In every other mode it stays 0.
- R7: Clocked slave (`sync_sel`=1, `clk_dir`=0) with `clk_pol`=0: each rising edge of `clk_in` gives one pulse on both `tx_tick` and `rx_tick`, three cycles after the edge is first sampled. The divisor has no effect on these outputs.
- R8: Clocked slave with `clk_pol`=1: falling edges of `clk_in` give the pulses and rising edges are ignored. Timing is as in R7.
- R9: Synchronous reset clears the counter, the post-divider, the synchroniser and all outputs. Outputs read 0 in the cycle after reset is sampled.
- R10: A divisor of zero gives a base tick in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_value | input | 12 | Baud divisor |
| div_lo_wr | input | 1 | Strobe for a write to the divisor low byte; forces a reload |
| sync_sel | input | 1 | 1 = clocked (synchronous) operation |
| speed2x | input | 1 | 1 = double speed in asynchronous operation |
| clk_dir | input | 1 | 1 = drive the serial clock (master), 0 = receive it (slave) |
| clk_pol | input | 1 | Slave edge select: 0 = rising, 1 = falling |
| clk_in | input | 1 | External serial clock input |
| tx_tick | output | 1 | Transmit clock enable |
| rx_tick | output | 1 | Receive base clock enable |
| clk_out | output | 1 | Serial clock output in master mode |

## Verification
A divisor write can land in the same cycle the counter reaches zero. The reload must then win, and that cycle must give no tick. The bench watches its own model of the counter and places strobes in exactly those cycles, as well as at arbitrary points. It then compares every output each cycle against a behavioural model that counts ticks with integers. In slave mode an external edge and a counter zero can also coincide. There the edge alone must decide both strobes, and the bench judges this by leaving the divisor small while `clk_in` toggles.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'd0,
    MODE_ASYNC_2X = 2'd1,
    MODE_MASTER   = 2'd2,
    MODE_SLAVE    = 2'd3
  } sclk_mode_e;

  function automatic sclk_mode_e decode_mode(input logic sync_sel, input logic speed2x,
                                             input logic clk_dir);
    if (!sync_sel) return speed2x ? MODE_ASYNC_2X : MODE_ASYNC;
    return clk_dir ? MODE_MASTER : MODE_SLAVE;
  endfunction
endpackage

// File: rtl/sclk_base_counter.sv
module sclk_base_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_value,
  input  logic             load,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  // a forced reload takes precedence over the zero crossing
  assign tick = at_zero && !load;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load || at_zero) cnt_q <= div_value;
    else                     cnt_q <= cnt_q - 1'b1;
  end

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(div_value));
  assert_countdown_R1: assert property (@(posedge clk) disable iff (rst)
    (!load && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sclk_post_div.sv
module sclk_post_div #(
  parameter int PDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [PDIV_W-1:0] mask,
  output logic              wrap,
  output logic              lsb_next
);
  logic [PDIV_W-1:0] pdiv_q;

  assign wrap     = tick && ((pdiv_q & mask) == mask);
  assign lsb_next = tick ? ~pdiv_q[0] : pdiv_q[0];

  always_ff @(posedge clk) begin
    if (rst)       pdiv_q <= '0;
    else if (tick) pdiv_q <= pdiv_q + 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pdiv_q));
endmodule

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [STAGES:0] sh_q;
  logic            cur, prev;

  assign cur  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
  assign edge_hit = fall_sel ? (prev && !cur) : (!prev && cur);

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], ext_clk};
  end

  assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> !edge_hit);
endmodule

// File: rtl/sclk_gen_top.sv
module sclk_gen_top #(
  parameter int DIV_W        = 12,
  parameter int ASYNC_DIV    = 16,
  parameter int ASYNC_2X_DIV = 8,
  parameter int MASTER_DIV   = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_lo_wr,
  input  logic             sync_sel,
  input  logic             speed2x,
  input  logic             clk_dir,
  input  logic             clk_pol,
  input  logic             clk_in,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             clk_out
);
  import sclk_gen_pkg::*;

  localparam int PDIV_W = $clog2(ASYNC_DIV);
  localparam logic [PDIV_W-1:0] MASK_ASYNC  = PDIV_W'(ASYNC_DIV - 1);
  localparam logic [PDIV_W-1:0] MASK_2X     = PDIV_W'(ASYNC_2X_DIV - 1);
  localparam logic [PDIV_W-1:0] MASK_MASTER = PDIV_W'(MASTER_DIV - 1);

  sclk_mode_e        mode;
  logic              base_tick, pd_wrap, pd_lsb, ext_edge;
  logic [PDIV_W-1:0] pd_mask;

  assign mode = decode_mode(sync_sel, speed2x, clk_dir);

  always_comb begin
    case (mode)
      MODE_ASYNC:    pd_mask = MASK_ASYNC;
      MODE_ASYNC_2X: pd_mask = MASK_2X;
      default:       pd_mask = MASK_MASTER;
    endcase
  end

  sclk_base_counter #(.DIV_W(DIV_W)) base_i (
    .clk(clk), .rst(rst), .div_value(div_value), .load(div_lo_wr), .tick(base_tick));

  sclk_post_div #(.PDIV_W(PDIV_W)) pdiv_i (
    .clk(clk), .rst(rst), .tick(base_tick), .mask(pd_mask),
    .wrap(pd_wrap), .lsb_next(pd_lsb));

  sclk_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .ext_clk(clk_in), .fall_sel(clk_pol), .edge_hit(ext_edge));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      tx_tick <= (mode == MODE_SLAVE) ? ext_edge : pd_wrap;
      rx_tick <= (mode == MODE_SLAVE) ? ext_edge : base_tick;
      clk_out <= (mode == MODE_MASTER) && pd_lsb;
    end
  end

  assert_tx_within_rx_R5: assert property (@(posedge clk) disable iff (rst)
    tx_tick |-> rx_tick);
  assert_clk_out_idle_R6: assert property (@(posedge clk) disable iff (rst)
    clk_out |-> $past(sync_sel && clk_dir));
  assert_slave_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_tick && $past(sync_sel && !clk_dir)) |-> tx_tick);
endmodule

// File: tb/sclk_gen_top_tb_top.sv
module sclk_gen_top_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] div_value = 12'd3;
  logic div_lo_wr = 0, sync_sel = 0, speed2x = 0, clk_dir = 0, clk_pol = 0, clk_in = 0;
  logic tx_tick, rx_tick, clk_out;

  always #4 clk = ~clk;

  sclk_gen_top dut_i (.clk(clk), .rst(rst), .div_value(div_value), .div_lo_wr(div_lo_wr),
    .sync_sel(sync_sel), .speed2x(speed2x), .clk_dir(clk_dir), .clk_pol(clk_pol),
    .clk_in(clk_in), .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out));

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0, m_hits = 0, x1 = 0, x2 = 0, x3 = 0;
  bit e_tx = 0, e_rx = 0, e_xck = 0, armed = 0;
  string tag_rx = "R9", tag_tx = "R9", tag_xck = "R9";
  int slave_tx_seen = 0;

  // behavioural model: integer tick counting, updated each rising edge
  always @(posedge clk) begin
    bit hit, edge_now, slave, master;
    int n;
    cycles++;
    if (rst) begin
      m_cnt = 0; m_hits = 0; x1 = 0; x2 = 0; x3 = 0;
      e_tx = 0; e_rx = 0; e_xck = 0;
      tag_rx = "R9"; tag_tx = "R9"; tag_xck = "R9";
    end else begin
      hit = (m_cnt == 0) && !div_lo_wr;
      if (div_lo_wr || m_cnt == 0) m_cnt = int'(div_value); else m_cnt--;
      edge_now = clk_pol ? (x3 == 1 && x2 == 0) : (x3 == 0 && x2 == 1);
      x3 = x2; x2 = x1; x1 = int'(clk_in);
      slave = sync_sel && !clk_dir;
      master = sync_sel && clk_dir;
      n = !sync_sel ? (speed2x ? 8 : 16) : 2;
      e_rx = slave ? edge_now : hit;
      e_tx = slave ? edge_now : (hit && (m_hits % n == n - 1));
      if (hit) m_hits++;
      e_xck = master && (m_hits % 2 == 1);
      if (slave) begin
        tag_rx = clk_pol ? "R8" : "R7"; tag_tx = tag_rx;
      end else begin
        tag_rx = div_lo_wr ? "R2" : (div_value == 0 ? "R10" : "R1");
        tag_tx = sync_sel ? "R5" : (speed2x ? "R4" : "R3");
      end
      tag_xck = "R6";
    end
    armed = 1;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (armed) begin
    check(tag_rx, "rx_tick", int'(rx_tick), int'(e_rx));
    check(tag_tx, "tx_tick", int'(tx_tick), int'(e_tx));
    check(tag_xck, "clk_out", int'(clk_out), int'(e_xck));
    if (sync_sel && !clk_dir && tx_tick) slave_tx_seen++;
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_write(logic [11:0] v);
    div_value = v; div_lo_wr = 1'b1;
    @(negedge clk);
    div_lo_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    // R9 reset state and R1/R3 async normal rate
    run(200);
    // R2 strobes at arbitrary points and exactly when the counter hits zero
    pulse_write(12'd5);
    run(7);
    pulse_write(12'd4);
    for (int k = 0; k < 6; k++) begin
      while (m_cnt != 0) @(negedge clk);
      pulse_write(12'd2 + 12'(k));
      run(3 + k);
    end
    // R4 double speed
    speed2x = 1'b1; div_value = 12'd2;
    run(150);
    // R10 divisor zero
    pulse_write(12'd0);
    run(80);
    // R5 and R6 master, double speed ignored
    sync_sel = 1'b1; clk_dir = 1'b1; div_value = 12'd1;
    run(100);
    speed2x = 1'b0; div_value = 12'd3;
    run(60);
    // R7 slave rising edges while the counter keeps hitting zero
    clk_dir = 1'b0; clk_pol = 1'b0; div_value = 12'd0;
    slave_tx_seen = 0;
    for (int k = 0; k < 10; k++) begin
      clk_in = ~clk_in;
      run(5);
    end
    run(5);
    check("R7", "slave edge count", slave_tx_seen, 5);
    // R8 falling edges, including fast toggling
    clk_pol = 1'b1;
    run(6);
    for (int k = 0; k < 20; k++) begin
      clk_in = ~clk_in;
      run(k < 10 ? 2 : 7);
    end
    // async with the external clock toggling has no effect on R1 ticks
    sync_sel = 1'b0; speed2x = 1'b0; div_value = 12'd1;
    for (int k = 0; k < 30; k++) begin
      clk_in = ~clk_in;
      run(3);
    end
    // R9 reset in mid stream
    rst = 1'b1;
    run(2);
    check("R9", "tx_tick in reset", int'(tx_tick), 0);
    check("R9", "rx_tick in reset", int'(rx_tick), 0);
    rst = 1'b0;
    run(40);
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    finish_run();
  end
endmodule